// File: doc/BRIEF.md
# Cache Test Register Port

This block gives test software direct access to the storage of a 4-way set-associative cache with a parameterised number of sets (256 by default). Software works through three 32-bit registers. A data register moves doublewords into a 128-bit fill buffer and out of a 128-bit read buffer. A tag/status register holds a tag and a valid bit for writing, and it returns tag, validity, tree-LRU bits and per-way coherence state after a read. A command register holds the set index, the way/word entry, the control code, a line-state code and a view-select bit. Writing the command register starts an operation.

Operations are fill-buffer load, read-buffer readout, line write, line read and a whole-cache flush. The flush walks one set per clock cycle. A mode input selects write-through or write-back handling. In write-back mode, line validity comes from a four-state coherence code: 00 invalid, 01 exclusive, 10 modified, 11 shared. In write-through mode, it comes from a single valid bit.

The controller is a state machine with four states. IDLE accepts register writes. LINE_WR stores the fill buffer, tag and state into the chosen way, then returns to IDLE. LINE_RD captures the chosen way into the read buffer and the tag/status register, then returns to IDLE. FLUSH clears one set per cycle and returns to IDLE after the last set. IDLE moves to LINE_WR, LINE_RD or FLUSH on a command write with control 01, 10 or 11. A command write with control 00 leaves it in IDLE.

Top module: `cache_test_port`

## Requirements
- R1: After reset, busy is 0 and all three registers read as zero. `wr_sel`/`rd_sel` codes are: 0 data, 1 tag/status, 2 command, 3 none (writes ignored, reads zero).
- R2: Command register layout: control in bits 1:0 (00 buffer access, 01 line write, 10 line read, 11 flush), entry in bits 3:2, set index in bits 11:4, state code in bits 18:17, view bit in bit 19. All other bits read as zero.
- R3: When the stored control is 00, a data-register write puts the word into fill-buffer word `entry`. A data-register read always returns read-buffer word `entry`. Word k of a line is bits 32k+31:32k.
- R4: A line write stores the fill buffer and the tag field (tag/status bits 31:11) into way `entry` of set `index`. The way's state is the command state code in write-back mode. In write-through mode it is 01 if the stored valid bit is 1, otherwise 00.
- R5: In write-back mode, a write to tag/status bit 10 is ignored. In write-through mode, that bit is stored.
- R6: In write-through mode, the view bit and the state code are not stored and read as zero, and the tag/status register always shows the tag view.
- R7: A line read loads the way's 128 data bits into the read buffer. It then shows the tag in bits 31:11, the accessed way's valid bit in bit 10, the set's LRU bits in 9:7, and way w's valid flag (state not 00) in bit 3+w.
- R8: When the view bit is 1 in write-back mode, the tag/status register shows way w's state in bits 21+2w:20+2w and the accessed way's state in bits 30:29. Bits 10:3 are as in R7, and all other bits are zero.
- R9: LRU bits {b2,b1,b0} change only on a line write or a flush. Accessing way 0 or 1 sets b0=1, and ways 2 or 3 set b0=0. Way 0 sets b1=1 and way 1 sets b1=0. Way 2 sets b2=1 and way 3 sets b2=0. Other bits are kept. Writes to bits 9:3 are ignored.
- R10: A flush command sets every way's state and every set's LRU bits to zero. Busy is high for exactly SETS cycles, starting on the cycle after the command is accepted.
- R11: While busy is high, all register writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wb_mode | input | 1 | 1 write-back handling, 0 write-through |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register selected for write |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Register selected for read |
| rd_data | output | 32 | Read data (combinational) |
| busy | output | 1 | Operation in progress |

## Verification
The assertions check the following on every cycle:
- the flush walks consecutive sets and ends after the last one;
- each cleared set really holds zero state and LRU;
- LRU bits stay put when no line write or flush happens;
- register writes during busy change nothing;
- write-through command writes leave the view and state fields zero;
- write-back writes to the valid bit leave it alone.

Only the bench scenarios can show that data, tags and states written to a way come back intact through a later line read. The same is true of the tree-LRU sequence over mixed way accesses, the two tag/status views, and the exact busy length of a flush.

// File: rtl/ctp_pkg.sv
package ctp_pkg;

    typedef enum logic [1:0] {
        CTL_BUF   = 2'b00,
        CTL_LWR   = 2'b01,
        CTL_LRD   = 2'b10,
        CTL_FLUSH = 2'b11
    } ctl_e;

    typedef enum logic [1:0] {
        SEL_DATA = 2'd0,
        SEL_TAG  = 2'd1,
        SEL_CMD  = 2'd2,
        SEL_NONE = 2'd3
    } sel_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LINE_WR,
        ST_LINE_RD,
        ST_FLUSH
    } ctp_state_e;

    // tree pseudo-LRU touch: bit0 root, bit1 pair {0,1}, bit2 pair {2,3}
    function automatic logic [2:0] plru_touch(input logic [2:0] cur, input logic [1:0] way);
        logic [2:0] nxt;
        nxt = cur;
        nxt[0] = ~way[1];
        if (!way[1]) nxt[1] = ~way[0];
        else         nxt[2] = ~way[0];
        return nxt;
    endfunction

endpackage

// File: rtl/ctp_ctrl.sv
module ctp_ctrl
    import ctp_pkg::*;
#(
    parameter int SETS = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  ctl_e             go_ctl,
    output logic             busy,
    output logic             line_wr,
    output logic             line_rd,
    output logic             clr_en,
    output logic [$clog2(SETS)-1:0] clr_set
);
    localparam int IDX_W = $clog2(SETS);
    localparam logic [IDX_W-1:0] LAST_SET = IDX_W'(SETS - 1);

    ctp_state_e state_q, state_d;
    logic [IDX_W-1:0] walk_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // flush walk counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  walk_q <= '0;
        else if (state_q == ST_FLUSH) walk_q <= walk_q + 1'b1;
        else                         walk_q <= '0;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (go) begin
                    unique case (go_ctl)
                        CTL_LWR:   state_d = ST_LINE_WR;
                        CTL_LRD:   state_d = ST_LINE_RD;
                        CTL_FLUSH: state_d = ST_FLUSH;
                        CTL_BUF:   state_d = ST_IDLE;
                    endcase
                end
            end
            ST_LINE_WR: state_d = ST_IDLE;
            ST_LINE_RD: state_d = ST_IDLE;
            ST_FLUSH:   if (walk_q == LAST_SET) state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy    = 1'b1;
        line_wr = 1'b0;
        line_rd = 1'b0;
        clr_en  = 1'b0;
        clr_set = walk_q;
        unique case (state_q)
            ST_IDLE:    busy    = 1'b0;
            ST_LINE_WR: line_wr = 1'b1;
            ST_LINE_RD: line_rd = 1'b1;
            ST_FLUSH:   clr_en  = 1'b1;
        endcase
    end

    // R10: the flush visits consecutive sets
    a_r10_flush_walk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && $past(clr_en)) |-> (clr_set == $past(clr_set) + 1'b1));

    // R10: the flush ends right after the last set
    a_r10_flush_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && clr_set == LAST_SET) |=> !busy);

endmodule

// File: rtl/ctp_store.sv
module ctp_store
    import ctp_pkg::*;
#(
    parameter int SETS   = 256,
    parameter int TAG_W  = 21,
    parameter int LINE_W = 128
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [$clog2(SETS)-1:0] acc_set,
    input  logic [1:0]              acc_way,
    output logic [TAG_W-1:0]        rd_tag,
    output logic [LINE_W-1:0]       rd_line,
    output logic [7:0]              rd_states,
    output logic [2:0]              rd_lru,
    input  logic                    wr_en,
    input  logic [TAG_W-1:0]        wr_tag,
    input  logic [LINE_W-1:0]       wr_line,
    input  logic [1:0]              wr_state,
    input  logic                    clr_en,
    input  logic [$clog2(SETS)-1:0] clr_set
);
    localparam int IDX_W = $clog2(SETS);
    localparam int WAYS  = 4;
    localparam int ENT   = SETS * WAYS;

    logic [TAG_W-1:0]  tag_mem  [ENT];
    logic [LINE_W-1:0] line_mem [ENT];
    logic [7:0]        st_mem   [SETS];
    logic [2:0]        lru_mem  [SETS];

    logic [IDX_W+1:0] addr;
    assign addr = {acc_set, acc_way};

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_mem[addr]  <= wr_tag;
            line_mem[addr] <= wr_line;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                st_mem[s]  <= '0;
                lru_mem[s] <= '0;
            end
        end else if (clr_en) begin
            st_mem[clr_set]  <= '0;
            lru_mem[clr_set] <= '0;
        end else if (wr_en) begin
            for (int w = 0; w < WAYS; w++) begin
                if (acc_way == 2'(w)) st_mem[acc_set][2*w +: 2] <= wr_state;
            end
            lru_mem[acc_set] <= plru_touch(lru_mem[acc_set], acc_way);
        end
    end

    assign rd_tag    = tag_mem[addr];
    assign rd_line   = line_mem[addr];
    assign rd_states = st_mem[acc_set];
    assign rd_lru    = lru_mem[acc_set];

    // R10: a cleared set holds no valid way and no LRU history
    a_r10_row_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> (st_mem[$past(clr_set)] == 8'd0 && lru_mem[$past(clr_set)] == 3'd0));

    // R9: LRU bits move only on a line write or flush
    a_r9_lru_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !clr_en) |=> (lru_mem[$past(acc_set)] == $past(rd_lru)));

endmodule

// File: rtl/cache_test_port.sv
module cache_test_port
    import ctp_pkg::*;
#(
    parameter int SETS = 256
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wb_mode,
    input  logic        wr_en,
    input  logic [1:0]  wr_sel,
    input  logic [31:0] wr_data,
    input  logic [1:0]  rd_sel,
    output logic [31:0] rd_data,
    output logic        busy
);
    localparam int IDX_W  = $clog2(SETS);
    localparam int TAG_W  = 21;
    localparam int LINE_W = 128;

    logic busy_i, line_wr, line_rd, clr_en;
    logic [IDX_W-1:0] clr_set;

    logic accept, wr_cmd, wr_dat, wr_tag;
    assign accept = wr_en && !busy_i;
    assign wr_cmd = accept && (wr_sel == SEL_CMD);
    assign wr_dat = accept && (wr_sel == SEL_DATA);
    assign wr_tag = accept && (wr_sel == SEL_TAG);

    // command register
    logic [IDX_W-1:0] cmd_idx;
    logic [1:0]       cmd_ent;
    ctl_e             cmd_ctl;
    logic             cmd_ext;
    logic [1:0]       cmd_ss;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_idx <= '0;
            cmd_ent <= '0;
            cmd_ctl <= CTL_BUF;
            cmd_ext <= 1'b0;
            cmd_ss  <= '0;
        end else if (wr_cmd) begin
            cmd_idx <= wr_data[4 +: IDX_W];
            cmd_ent <= wr_data[3:2];
            cmd_ctl <= ctl_e'(wr_data[1:0]);
            cmd_ext <= wb_mode & wr_data[19];
            cmd_ss  <= wb_mode ? wr_data[18:17] : 2'b00;
        end
    end

    // buffers and tag/status register
    logic [3:0][31:0] fill_buf, read_buf;
    logic [TAG_W-1:0] ts_tag;
    logic             ts_valid;
    logic [2:0]       ts_lru;
    logic [7:0]       ts_states;
    logic [1:0]       ts_cur;

    logic [TAG_W-1:0]  rd_tag;
    logic [LINE_W-1:0] rd_line;
    logic [7:0]        rd_states;
    logic [2:0]        rd_lru;
    logic [1:0]        cur_state;
    assign cur_state = rd_states[{cmd_ent, 1'b0} +: 2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fill_buf <= '0;
        end else if (wr_dat && cmd_ctl == CTL_BUF) begin
            fill_buf[cmd_ent] <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            read_buf  <= '0;
            ts_tag    <= '0;
            ts_valid  <= 1'b0;
            ts_lru    <= '0;
            ts_states <= '0;
            ts_cur    <= '0;
        end else if (line_rd) begin
            read_buf  <= rd_line;
            ts_tag    <= rd_tag;
            ts_valid  <= |cur_state;
            ts_lru    <= rd_lru;
            ts_states <= rd_states;
            ts_cur    <= cur_state;
        end else if (wr_tag) begin
            ts_tag <= wr_data[31:11];
            if (!wb_mode) ts_valid <= wr_data[10];
        end
    end

    logic [1:0] wr_state;
    assign wr_state = wb_mode ? cmd_ss : {1'b0, ts_valid};

    ctp_ctrl #(.SETS(SETS)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (wr_cmd),
        .go_ctl  (ctl_e'(wr_data[1:0])),
        .busy    (busy_i),
        .line_wr (line_wr),
        .line_rd (line_rd),
        .clr_en  (clr_en),
        .clr_set (clr_set)
    );

    ctp_store #(.SETS(SETS), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_set   (cmd_idx),
        .acc_way   (cmd_ent),
        .rd_tag    (rd_tag),
        .rd_line   (rd_line),
        .rd_states (rd_states),
        .rd_lru    (rd_lru),
        .wr_en     (line_wr),
        .wr_tag    (ts_tag),
        .wr_line   (fill_buf),
        .wr_state  (wr_state),
        .clr_en    (clr_en),
        .clr_set   (clr_set)
    );

    // read-out views
    logic [31:0] ts_view, cmd_view;
    always_comb begin
        ts_view = '0;
        if (cmd_ext && wb_mode) begin
            ts_view[30:29] = ts_cur;
            ts_view[27:20] = ts_states;
        end else begin
            ts_view[31:11] = ts_tag;
        end
        ts_view[10]  = ts_valid;
        ts_view[9:7] = ts_lru;
        for (int w = 0; w < 4; w++) ts_view[3+w] = |ts_states[2*w +: 2];
    end

    always_comb begin
        cmd_view = '0;
        cmd_view[19]         = cmd_ext & wb_mode;
        cmd_view[18:17]      = wb_mode ? cmd_ss : 2'b00;
        cmd_view[4 +: IDX_W] = cmd_idx;
        cmd_view[3:2]        = cmd_ent;
        cmd_view[1:0]        = cmd_ctl;
    end

    always_comb begin
        unique case (rd_sel)
            SEL_DATA: rd_data = read_buf[cmd_ent];
            SEL_TAG:  rd_data = ts_view;
            SEL_CMD:  rd_data = cmd_view;
            SEL_NONE: rd_data = '0;
        endcase
    end

    assign busy = busy_i;

    // R11: writes during an operation leave the registers alone
    a_r11_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && wr_en) |=> ($stable(cmd_idx) && $stable(cmd_ent) && $stable(fill_buf)));

    // R6: write-through command writes store no view bit or state code
    a_r6_wt_fields: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmd && !wb_mode) |=> (cmd_ext == 1'b0 && cmd_ss == 2'b00));

    // R5: write-back valid bit ignores tag/status writes
    a_r5_wb_valid_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_tag && wb_mode && !line_rd) |=> (ts_valid == $past(ts_valid)));

    // R3: data writes outside buffer mode leave the fill buffer
    a_r3_fill_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_dat && cmd_ctl != CTL_BUF) |=> $stable(fill_buf));

endmodule

// File: tb/cache_test_port_test.sv
module cache_test_port_test;
    localparam int CLK_PERIOD = 10;
    localparam int SETS = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wb_mode = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd3;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_sel = 2'd3;
    logic [31:0] rd_data;
    logic        busy;

    cache_test_port #(.SETS(SETS)) uut (
        .clk(clk), .rst_n(rst_n), .wb_mode(wb_mode), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
        .rd_data(rd_data), .busy(busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // reference model
    logic [20:0]  m_tag  [SETS*4];
    logic [127:0] m_line [SETS*4];
    logic [7:0]   m_st   [SETS];
    logic [2:0]   m_lru  [SETS];
    logic [7:0]   m_idx;
    logic [1:0]   m_ent, m_ctl, m_ss;
    logic         m_ext;
    logic [3:0][31:0] m_fill, m_rbuf;
    logic [20:0]  t_tag;
    logic         t_valid;
    logic [2:0]   t_lru;
    logic [7:0]   t_states;
    logic [1:0]   t_cur;

    function automatic logic [2:0] lru_next(input logic [2:0] l, input logic [1:0] w);
        logic [2:0] n = l;
        n[0] = (w < 2);
        if (w == 2'd0) n[1] = 1'b1;
        if (w == 2'd1) n[1] = 1'b0;
        if (w == 2'd2) n[2] = 1'b1;
        if (w == 2'd3) n[2] = 1'b0;
        return n;
    endfunction

    function automatic logic [31:0] exp_ts();
        logic [31:0] r = '0;
        if (m_ext && wb_mode) begin
            r[30:29] = t_cur;
            r[27:20] = t_states;
        end else r[31:11] = t_tag;
        r[10] = t_valid;
        r[9:7] = t_lru;
        for (int w = 0; w < 4; w++) r[3+w] = (t_states[2*w +: 2] != 2'b00);
        return r;
    endfunction

    function automatic logic [31:0] exp_cmd();
        logic [31:0] r = '0;
        r[19] = m_ext && wb_mode;
        r[18:17] = wb_mode ? m_ss : 2'b00;
        r[11:4] = m_idx;
        r[3:2] = m_ent;
        r[1:0] = m_ctl;
        return r;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic model_write(input logic [1:0] s, input logic [31:0] d);
        int a;
        logic [1:0] st;
        if (s == 2'd2) begin
            m_idx = d[11:4]; m_ent = d[3:2]; m_ctl = d[1:0];
            m_ext = wb_mode & d[19];
            m_ss  = wb_mode ? d[18:17] : 2'b00;
            a = {m_idx, m_ent};
            if (m_ctl == 2'b01) begin
                m_tag[a] = t_tag;
                m_line[a] = m_fill;
                st = wb_mode ? m_ss : {1'b0, t_valid};
                m_st[m_idx][2*m_ent +: 2] = st;
                m_lru[m_idx] = lru_next(m_lru[m_idx], m_ent);
            end else if (m_ctl == 2'b10) begin
                m_rbuf = m_line[a];
                t_tag = m_tag[a];
                t_states = m_st[m_idx];
                t_lru = m_lru[m_idx];
                t_cur = m_st[m_idx][2*m_ent +: 2];
                t_valid = (t_cur != 2'b00);
            end else if (m_ctl == 2'b11) begin
                for (int i = 0; i < SETS; i++) begin m_st[i] = '0; m_lru[i] = '0; end
            end
        end else if (s == 2'd0) begin
            if (m_ctl == 2'b00) m_fill[m_ent] = d;
        end else if (s == 2'd1) begin
            t_tag = d[31:11];
            if (!wb_mode) t_valid = d[10];
        end
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic wreg(input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        model_write(s, d);
        wait_idle();
    endtask

    task automatic rreg(input logic [1:0] s, output logic [31:0] v);
        @(negedge clk);
        rd_sel = s;
        #1 v = rd_data;
    endtask

    function automatic logic [31:0] mk_cmd(input logic [7:0] idx, input logic [1:0] ent,
                                           input logic [1:0] ctl, input logic [1:0] ss, input logic ext);
        return {12'd0, ext, ss, 5'd0, idx, ent, ctl};
    endfunction

    task automatic write_line(input logic [7:0] idx, input logic [1:0] way, input logic [1:0] ss,
                              input logic [20:0] tag, input logic vbit);
        for (int k = 0; k < 4; k++) begin
            wreg(2'd2, mk_cmd(idx, 2'(k), 2'b00, 2'b00, 1'b0));
            wreg(2'd0, $urandom);
        end
        wreg(2'd1, {tag, vbit, 10'd0});
        wreg(2'd2, mk_cmd(idx, way, 2'b01, ss, 1'b0));
    endtask

    task automatic read_and_check(input string req, input logic [7:0] idx, input logic [1:0] way,
                                  input logic ext);
        logic [31:0] v;
        wreg(2'd2, mk_cmd(idx, way, 2'b10, 2'b00, ext));
        rreg(2'd1, v); chk({req, " tag/status view"}, v, exp_ts());
        for (int k = 0; k < 4; k++) begin
            wreg(2'd2, mk_cmd(idx, 2'(k), 2'b00, 2'b00, ext));
            rreg(2'd0, v); chk("R3 R7 read buffer word", v, m_rbuf[k]);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog all act=running exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int n;
        logic [7:0] sets_used [4];
        void'($urandom(32'h5EED_C0DE));
        sets_used[0] = 8'd0; sets_used[1] = 8'd1; sets_used[2] = 8'd2; sets_used[3] = 8'd255;
        for (int i = 0; i < SETS; i++) begin m_st[i] = '0; m_lru[i] = '0; end
        m_idx = '0; m_ent = '0; m_ctl = '0; m_ss = '0; m_ext = 1'b0;
        m_fill = '0; m_rbuf = '0;
        t_tag = '0; t_valid = 1'b0; t_lru = '0; t_states = '0; t_cur = '0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        chk("R1 busy after reset", {31'd0, busy}, 32'd0);
        for (int s = 0; s < 4; s++) begin
            rreg(2'(s), v); chk("R1 register after reset", v, 32'd0);
        end

        // initialise all ways of four sets in write-back mode, each state code once
        wb_mode = 1'b1;
        for (int si = 0; si < 4; si++)
            for (int w = 0; w < 4; w++)
                write_line(sets_used[si], 2'(w), 2'(w + si), 21'($urandom), 1'b0);

        // R2 command readback in write-back mode
        wreg(2'd2, 32'hFFFF_FFF0 | mk_cmd(8'hA5, 2'd2, 2'b00, 2'b11, 1'b1));
        rreg(2'd2, v); chk("R2 command readback", v, exp_cmd());

        // R7 R8 R4 reads of every way, both views
        for (int w = 0; w < 4; w++) read_and_check("R4 R7", 8'd255, 2'(w), 1'b0);
        read_and_check("R8 status view", 8'd1, 2'd3, 1'b1);

        // R9 LRU sequence on set 2
        write_line(8'd2, 2'd0, 2'b01, 21'h1, 1'b0);
        write_line(8'd2, 2'd3, 2'b10, 21'h2, 1'b0);
        read_and_check("R9 LRU after way0,way3", 8'd2, 2'd1, 1'b0);
        // R9 writes to LRU/valid bits ignored
        wreg(2'd1, 32'h0000_03F8);
        rreg(2'd1, v); chk("R9 LRU/valid bits ignore writes", v, exp_ts());

        // R5 write-back ignores bit 10
        wreg(2'd1, 32'h0000_0400);
        rreg(2'd1, v); chk("R5 wb valid write ignored", v[10], {31'd0, t_valid});

        // R6 write-through mode
        wb_mode = 1'b0;
        wreg(2'd2, mk_cmd(8'd3, 2'd1, 2'b00, 2'b10, 1'b1));
        rreg(2'd2, v); chk("R6 wt command fields zero", v, exp_cmd());
        write_line(8'd0, 2'd1, 2'b11, 21'h155, 1'b1);
        read_and_check("R4 R6 wt line valid", 8'd0, 2'd1, 1'b1);
        write_line(8'd0, 2'd2, 2'b11, 21'h0AA, 1'b0);
        read_and_check("R4 R6 wt line invalid", 8'd0, 2'd2, 1'b0);
        wreg(2'd1, 32'h0000_0400);
        rreg(2'd1, v); chk("R5 wt valid write stored", v[10], 32'd1);

        // R3 data write outside buffer mode is ignored
        wb_mode = 1'b1;
        wreg(2'd2, mk_cmd(8'd9, 2'd0, 2'b10, 2'b00, 1'b0));
        wreg(2'd0, 32'hDEAD_BEEF);
        write_line(8'd1, 2'd2, 2'b10, 21'h777, 1'b0);
        read_and_check("R3 fill after ignored write", 8'd1, 2'd2, 1'b0);

        // R1 unused select
        wreg(2'd3, 32'hFFFF_FFFF);
        rreg(2'd3, v); chk("R1 select 3 reads zero", v, 32'd0);
        rreg(2'd2, v); chk("R1 select 3 write ignored", v, exp_cmd());

        // R10 R11 flush with busy length and held-off writes
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 2'd2; wr_data = mk_cmd(8'd4, 2'd1, 2'b11, 2'b00, 1'b0);
        @(negedge clk);
        model_write(2'd2, wr_data);
        wr_sel = 2'd2; wr_data = mk_cmd(8'd7, 2'd3, 2'b01, 2'b01, 1'b0);
        n = 0;
        while (busy) begin n++; @(negedge clk); end
        wr_en = 1'b0;
        chk("R10 flush busy cycles", n, SETS);
        rreg(2'd2, v); chk("R11 command write during busy ignored", v, exp_cmd());
        read_and_check("R10 after flush", 8'd255, 2'd0, 1'b1);
        read_and_check("R10 after flush", 8'd2, 2'd3, 1'b0);

        // constrained random mix over the initialised sets
        for (int w = 0; w < 4; w++)
            for (int si = 0; si < 4; si++)
                write_line(sets_used[si], 2'(w), 2'($urandom), 21'($urandom), 1'b1);
        for (int it = 0; it < 120; it++) begin
            int op = $urandom % 5;
            logic [7:0] s = sets_used[$urandom % 4];
            logic [1:0] w = 2'($urandom);
            wb_mode = ($urandom % 3) != 0;
            case (op)
                0, 1: write_line(s, w, 2'($urandom), 21'($urandom), 1'($urandom));
                2:    read_and_check("R7 R8 random read", s, w, 1'($urandom));
                3: begin
                    wreg(2'd1, $urandom);
                    rreg(2'd1, v); chk("R5 R6 random tag write", v, exp_ts());
                end
                default: begin
                    wreg(2'd2, $urandom & 32'h000F_FFFC);
                    rreg(2'd2, v); chk("R2 R6 random command", v, exp_cmd());
                end
            endcase
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule